// File: doc/BRIEF.md
# Supply Monitor Power-On Reset Sequencer

This block turns a digital "voltage above reference" flag from an external comparator into an active-low system reset. While the monitored supply is low, reset is held. Once the supply rises above the reference, reset is held for a further power-on delay of `40 * PULSE_TICKS` time-base ticks. That delay equals the watchdog period, which is forty watchdog reset-pulse lengths. Reset is then released, and a one-cycle ready pulse hands control to the watchdog.

In the released state, short dips of the comparator flag are filtered by a counter of clock cycles. The counter is cleared whenever the synchronized flag reads high. A dip that lasts `SENSE_CYCLES` cycles or more is a qualified brown-out. It forces reset low at once and overrides whatever the watchdog is doing. A separate asynchronous power-good flag forces reset with no filtering. The hold output stays high whenever reset is asserted. The watchdog uses it to ignore clear pulses and to keep its enable output inactive until a full new power-up sequence has completed.

Both asynchronous flags pass through two-flop synchronizers. The block uses a synchronous active-high reset `rst`.

Top module: `por_sequencer`

## Requirements
- R1: While `rst` is high and in the cycles after it, `sys_rst_n` is 0, `ready_pulse` is 0 and `wd_hold` is 1, until a power-up sequence completes.
- R2: While `above_ref_a` stays 0, `sys_rst_n` stays 0 for any length of time.
- R3: When `above_ref_a` rises and `tick` is high every cycle, `sys_rst_n` goes to 1 exactly POR_TICKS+3 clock edges later: 2 for the synchronizer, 1 to enter the delay state and POR_TICKS counted ticks. POR_TICKS = 40*PULSE_TICKS.
- R4: `ready_pulse` is 1 for exactly one cycle, in the same cycle that `sys_rst_n` first reads 1, and is 0 otherwise.
- R5: After release, a comparator dip shorter than SENSE_CYCLES cycles leaves `sys_rst_n` at 1.
- R6: After release, a comparator dip of SENSE_CYCLES cycles or more drives `sys_rst_n` to 0. With a dip of exactly SENSE_CYCLES cycles, this happens SENSE_CYCLES+3 edges after the dip starts.
- R7: `wd_hold` is 1 in every cycle in which `sys_rst_n` is 0, and 0 only while reset is released.
- R8: A comparator drop of any length during the power-on delay restarts the delay in full. Release then comes POR_TICKS+3 edges after the flag rises again.
- R9: `supply_ok_a` at 0 drives `sys_rst_n` to 0 three edges later, with no dip filtering.
- R10: Delay ticks are counted only in cycles with `tick` high. Cycles with `tick` low extend the power-on delay one for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick, one cycle wide, counts the power-on delay |
| supply_ok_a | input | 1 | Asynchronous power-good flag, high when the supply is usable |
| above_ref_a | input | 1 | Asynchronous comparator flag, high when the monitored voltage exceeds the reference |
| sys_rst_n | output | 1 | Active-low system reset |
| ready_pulse | output | 1 | One-cycle pulse when reset is released |
| wd_hold | output | 1 | High while watchdog clear pulses are to be ignored and enable is forced off |

## Verification
Each result has a fixed latency, counted in clock edges from the falling clock edge where the bench changes an input:
- Release comes POR_TICKS+3 edges after the comparator rises, and later by one edge for each tick-free cycle.
- A qualified dip asserts reset SENSE_CYCLES+3 edges after it starts.
- A power-good loss asserts reset three edges after it occurs.

The bench steps exactly that many falling edges and checks that the output has not yet changed one edge early and has changed on the due edge. Dip lengths around the filter threshold are checked over a window long enough to catch any late assertion.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    // Watchdog period expressed in watchdog reset-pulse lengths.
    localparam int unsigned WD_PERIOD_PULSES = 40;

    typedef enum logic [1:0] {
        PS_LOW  = 2'd0,   // supply below reference, reset held
        PS_HOLD = 2'd1,   // supply good, counting the power-on delay
        PS_RUN  = 2'd2    // reset released, watchdog in control
    } por_state_e;

    // Counter width able to hold values 0..n-1.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // One independent two-flop chain per bit; reset value 0 means "not good".
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/por_dip_filter.sv
module por_dip_filter
    import por_seq_pkg::*;
#(
    parameter int unsigned SENSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic level_ok,
    output logic brown
);
    localparam int unsigned DW = cnt_w(SENSE_CYCLES + 1);
    localparam logic [DW-1:0] SAT = DW'(SENSE_CYCLES);

    logic [DW-1:0] low_cnt;

    // Consecutive low samples, cleared by any high sample, saturating.
    always_ff @(posedge clk) begin
        if (rst)                low_cnt <= '0;
        else if (level_ok)      low_cnt <= '0;
        else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
    end

    assign brown = (low_cnt == SAT);

    // R5: a high sample always withdraws the qualified brown-out.
    assert_high_clears_R5: assert property (@(posedge clk) disable iff (rst)
        level_ok |=> !brown);

    // R6: counter never runs past the qualification threshold.
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= SAT);
endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
    import por_seq_pkg::*;
#(
    parameter int unsigned POR_TICKS = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       level_ok,
    input  logic       brown,
    input  logic       tick,
    output por_state_e state,
    output logic       ready
);
    localparam int unsigned CW = cnt_w(POR_TICKS);
    localparam logic [CW-1:0] LAST = CW'(POR_TICKS - 1);

    logic [CW-1:0] dly_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_LOW;
            dly_cnt <= '0;
            ready   <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (!supply_ok) begin
                state   <= PS_LOW;
                dly_cnt <= '0;
            end else begin
                unique case (state)
                    PS_LOW: begin
                        if (level_ok) begin
                            state   <= PS_HOLD;
                            dly_cnt <= '0;
                        end
                    end
                    PS_HOLD: begin
                        if (!level_ok) begin
                            state <= PS_LOW;
                        end else if (tick) begin
                            if (dly_cnt == LAST) begin
                                state <= PS_RUN;
                                ready <= 1'b1;
                            end else begin
                                dly_cnt <= dly_cnt + 1'b1;
                            end
                        end
                    end
                    PS_RUN: begin
                        if (brown) state <= PS_LOW;
                    end
                    default: state <= PS_LOW;
                endcase
            end
        end
    end

    // R9: power-good loss wins over every state.
    assert_pg_loss_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (state == PS_LOW));

    // R6: qualified brown-out in run returns to the low state.
    assert_brown_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN && brown) |=> (state == PS_LOW));

    // R8: any drop during the delay abandons the count.
    assert_hold_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PS_HOLD && !level_ok) |=> (state == PS_LOW));

    // R4: ready lasts a single cycle.
    assert_ready_single_R4: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R10: the delay count moves only on a tick.
    assert_tick_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (state == PS_HOLD && level_ok && supply_ok && !tick) |=> $stable(dly_cnt));
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
    import por_seq_pkg::*;
#(
    parameter int unsigned PULSE_TICKS  = 4,
    parameter int unsigned SENSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic supply_ok_a,
    input  logic above_ref_a,
    output logic sys_rst_n,
    output logic ready_pulse,
    output logic wd_hold
);
    localparam int unsigned POR_TICKS = WD_PERIOD_PULSES * PULSE_TICKS;

    logic [1:0] sync_q;
    logic       supply_ok;
    logic       level_ok;
    logic       brown;
    por_state_e state;

    por_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({supply_ok_a, above_ref_a}),
        .q   (sync_q)
    );

    assign supply_ok = sync_q[1];
    assign level_ok  = sync_q[0];

    por_dip_filter #(.SENSE_CYCLES(SENSE_CYCLES)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .level_ok (level_ok),
        .brown    (brown)
    );

    por_seq_fsm #(.POR_TICKS(POR_TICKS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .level_ok  (level_ok),
        .brown     (brown),
        .tick      (tick),
        .state     (state),
        .ready     (ready_pulse)
    );

    assign sys_rst_n = (state == PS_RUN);
    assign wd_hold   = (state != PS_RUN);

    // R4: reset is released only together with the ready pulse.
    assert_release_ready_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> ready_pulse);

    // R1: no release while the synchronous reset is applied.
    assert_rst_hold_R1: assert property (@(posedge clk)
        rst |=> !sys_rst_n);
endmodule

// File: tb/por_sequencer_test.sv
module por_sequencer_test;
    localparam int unsigned PULSE_TICKS  = 4;
    localparam int unsigned SENSE_CYCLES = 8;
    localparam int unsigned P            = 40 * PULSE_TICKS;
    localparam int unsigned NVEC         = 6;
    // Each vector: dip length in cycles (bits 8:1), expect reset (bit 0).
    localparam logic [8:0] VEC [NVEC] = '{
        {8'd1, 1'b0}, {8'd3, 1'b0}, {8'd7, 1'b0},
        {8'd8, 1'b1}, {8'd9, 1'b1}, {8'd20, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic supply_ok_a = 1'b1;
    logic above_ref_a = 1'b0;
    logic sys_rst_n, ready_pulse, wd_hold;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;

    por_sequencer #(.PULSE_TICKS(PULSE_TICKS), .SENSE_CYCLES(SENSE_CYCLES)) uut (
        .clk(clk), .rst(rst), .tick(tick), .supply_ok_a(supply_ok_a),
        .above_ref_a(above_ref_a), .sys_rst_n(sys_rst_n),
        .ready_pulse(ready_pulse), .wd_hold(wd_hold)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, cycles actual %0d expected <= 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Waits for release with a bound; used to return to the run state.
    task automatic wait_release(input string req);
        int k = 0;
        while (!sys_rst_n && k < P + 60) begin step(1); k++; end
        chk(req, "release reached", int'(sys_rst_n), 1);
    endtask

    initial begin
        step(3);
        // R1: state under and right after reset
        chk("R1", "sys_rst_n in reset", int'(sys_rst_n), 0);
        chk("R1", "ready in reset", int'(ready_pulse), 0);
        chk("R1", "hold in reset", int'(wd_hold), 1);
        rst = 1'b0;
        step(300);
        // R2: comparator low keeps reset
        chk("R2", "sys_rst_n with supply low", int'(sys_rst_n), 0);
        chk("R7", "hold with reset low", int'(wd_hold), 1);

        // R3/R4: exact release latency
        above_ref_a = 1'b1;
        step(P + 2);
        chk("R3", "sys_rst_n one edge early", int'(sys_rst_n), 0);
        chk("R4", "ready one edge early", int'(ready_pulse), 0);
        step(1);
        chk("R3", "sys_rst_n at due edge", int'(sys_rst_n), 1);
        chk("R4", "ready at release", int'(ready_pulse), 1);
        chk("R7", "hold after release", int'(wd_hold), 0);
        step(1);
        chk("R4", "ready next cycle", int'(ready_pulse), 0);

        // R5/R6: table of dip lengths
        for (int v = 0; v < NVEC; v++) begin
            int unsigned len = int'(VEC[v][8:1]);
            bit exp_rst = VEC[v][0];
            bit saw_low = 1'b0;
            bit hold_bad = 1'b0;
            above_ref_a = 1'b0;
            for (int c = 0; c < SENSE_CYCLES + 26; c++) begin
                if (c == int'(len)) above_ref_a = 1'b1;
                step(1);
                if (!sys_rst_n) saw_low = 1'b1;
                if (wd_hold != !sys_rst_n) hold_bad = 1'b1;
            end
            above_ref_a = 1'b1;
            chk(exp_rst ? "R6" : "R5", $sformatf("reset seen for dip %0d", len),
                int'(saw_low), int'(exp_rst));
            chk("R7", "hold tracks reset", int'(hold_bad), 0);
            wait_release(exp_rst ? "R6" : "R5");
        end

        // R6: exact brown-out latency for a dip of SENSE_CYCLES
        step(2);
        above_ref_a = 1'b0;
        step(SENSE_CYCLES);
        above_ref_a = 1'b1;
        step(2);
        chk("R6", "sys_rst_n one edge early", int'(sys_rst_n), 1);
        step(1);
        chk("R6", "sys_rst_n at due edge", int'(sys_rst_n), 0);
        chk("R7", "hold after brown-out", int'(wd_hold), 1);
        wait_release("R6");

        // R9: power-good loss, unfiltered
        step(2);
        supply_ok_a = 1'b0;
        step(2);
        chk("R9", "sys_rst_n one edge early", int'(sys_rst_n), 1);
        step(1);
        chk("R9", "sys_rst_n at due edge", int'(sys_rst_n), 0);
        supply_ok_a = 1'b1;
        wait_release("R9");

        // R8: drop during the delay restarts it in full
        step(2);
        supply_ok_a = 1'b0;
        step(4);
        supply_ok_a = 1'b1;
        step(P / 2);
        above_ref_a = 1'b0;
        step(1);
        above_ref_a = 1'b1;
        step(P + 2);
        chk("R8", "sys_rst_n one edge before restarted delay ends", int'(sys_rst_n), 0);
        step(1);
        chk("R8", "sys_rst_n after restarted delay", int'(sys_rst_n), 1);

        // R10: stalled ticks extend the delay
        above_ref_a = 1'b0;
        step(SENSE_CYCLES + 6);
        chk("R6", "reset after long drop", int'(sys_rst_n), 0);
        above_ref_a = 1'b1;
        tick = 1'b0;
        step(20);
        tick = 1'b1;
        step(P - 1);
        chk("R10", "sys_rst_n one edge early with stall", int'(sys_rst_n), 0);
        step(1);
        chk("R10", "sys_rst_n at due edge with stall", int'(sys_rst_n), 1);
        chk("R4", "ready with stall", int'(ready_pulse), 1);

        summary();
        $finish;
    end
endmodule